// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general-purpose registers of a processor whose operating mode decides which physical word some register names reach. It has two combinational read ports, one write port and a 3-bit mode input. Each port names an architectural register with 4 bits. A mapper translates that name, under the current mode, into one of 31 physical storage words.

Names 0 to 7 and name 15 always reach the same word. Names 8 to 12 have a second private set that only the fast-interrupt mode uses. Each exception mode has its own copy of names 13 (stack pointer) and 14 (link). User and system mode share one bank.

The control logic around the block decides when the mode changes. The block only applies the mode it is given in each cycle.

Top module: `banked_regfile`

## Requirements
- R1: Names 0 to 7 reach the same physical word in every mode. A value written in one mode is read back in any other mode.
- R2: In fast-interrupt mode (mode 1), names 8 to 12 reach a private set. In every other mode they reach the user set. A write to one set leaves the other set unchanged.
- R3: Name 13 has a private copy in each of the modes fast-interrupt (1), interrupt (2), supervisor (3), abort (4) and undefined (5). User (0) and system (6) share one copy.
- R4: Name 14 is banked exactly like name 13.
- R5: Name 15 is one unbanked word. It is read and written as an ordinary register in every mode.
- R6: With `wr_en` high, the word chosen by `wr_name` under the current mode takes `wr_data` at the rising clock edge. With `wr_en` low, no word changes.
- R7: Reads are combinational on the current mode and name. A read of the entry being written in the same cycle returns the old value until the edge.
- R8: A synchronous active-high reset clears every physical word to zero.
- R9: The two read ports are independent. Each returns the word its own name selects.
- R10: Mode encoding 7 is treated as user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Current operating mode |
| rd_a_name | input | 4 | Read port A register name |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_name | input | 4 | Read port B register name |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_name | input | 4 | Write register name |
| wr_data | input | DATA_W | Write data |

## Verification
The bench builds the block at its default 32-bit width. The full-width data patterns used make a word that lands in the wrong physical slot show up as a wrong upper or lower byte.

Because every check writes in one mode and reads in another, each bank boundary is crossed in both directions:
- fast-interrupt against user for names 8 to 12;
- each exception mode against its neighbours for names 13 and 14;
- the reserved encoding against user mode.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;
  localparam int NAME_W  = 4;
  localparam int MODE_W  = 3;
  localparam int PHYS_N  = 31;
  localparam int PHYS_W  = $clog2(PHYS_N);

  typedef enum logic [MODE_W-1:0] {
    MD_USER  = 3'd0,
    MD_FAST  = 3'd1,
    MD_IRQ   = 3'd2,
    MD_SUPER = 3'd3,
    MD_ABORT = 3'd4,
    MD_UNDEF = 3'd5,
    MD_SYS   = 3'd6,
    MD_RSVD  = 3'd7
  } op_mode_e;

  // physical layout
  localparam int SLOT_PC    = 15;
  localparam int SLOT_FAST  = 16;  // 16..22 : names 8..14 in fast mode
  localparam int SLOT_IRQ   = 23;  // 23,24
  localparam int SLOT_SUPER = 25;  // 25,26
  localparam int SLOT_ABORT = 27;  // 27,28
  localparam int SLOT_UNDEF = 29;  // 29,30
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import banked_regfile_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [NAME_W-1:0] name,
  output logic [PHYS_W-1:0] slot
);
  logic        is_sp_lr;
  logic        is_hi;
  logic [PHYS_W-1:0] exc_base;

  assign is_hi    = (name >= 4'd8) && (name <= 4'd14);
  assign is_sp_lr = (name == 4'd13) || (name == 4'd14);

  always_comb begin
    case (op_mode_e'(mode))
      MD_IRQ:   exc_base = PHYS_W'(SLOT_IRQ);
      MD_SUPER: exc_base = PHYS_W'(SLOT_SUPER);
      MD_ABORT: exc_base = PHYS_W'(SLOT_ABORT);
      MD_UNDEF: exc_base = PHYS_W'(SLOT_UNDEF);
      default:  exc_base = '0;
    endcase
  end

  always_comb begin
    slot = PHYS_W'(name);
    if (is_hi && (op_mode_e'(mode) == MD_FAST))
      slot = PHYS_W'(SLOT_FAST) + PHYS_W'(name - 4'd8);
    else if (is_sp_lr && (exc_base != '0))
      slot = exc_base + PHYS_W'(name - 4'd13);
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      words[waddr] <= wdata;
    end
  end

  assign rdata_a = (int'(raddr_a) < DEPTH) ? words[raddr_a] : '0;
  assign rdata_b = (int'(raddr_b) < DEPTH) ? words[raddr_b] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [3:0]        rd_a_name,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_name,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_name,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int PORTS = 3;  // 0: read A, 1: read B, 2: write

  logic [NAME_W-1:0] port_name [PORTS];
  logic [PHYS_W-1:0] port_slot [PORTS];

  assign port_name[0] = rd_a_name;
  assign port_name[1] = rd_b_name;
  assign port_name[2] = wr_name;

  for (genvar p = 0; p < PORTS; p++) begin : g_map
    rf_bank_map u_map (
      .mode (mode),
      .name (port_name[p]),
      .slot (port_slot[p])
    );
  end

  rf_store #(
    .DATA_W (DATA_W),
    .DEPTH  (PHYS_N),
    .ADDR_W (PHYS_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (port_slot[2]),
    .wdata   (wr_data),
    .raddr_a (port_slot[0]),
    .rdata_a (rd_a_data),
    .raddr_b (port_slot[1]),
    .rdata_b (rd_b_data)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode,
  input logic [3:0]        rd_a_name,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_name,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_name,
  input logic [DATA_W-1:0] wr_data
);
  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((rd_a_name != $past(wr_name)) || (mode != $past(mode)) ||
               (rd_a_data == $past(wr_data))));

  // R6
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((rd_a_name != $past(rd_a_name)) || (mode != $past(mode)) ||
                (rd_a_data == $past(rd_a_data))));

  // R8
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((rd_a_data == '0) && (rd_b_data == '0)));

  // R9
  ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_name == rd_b_name) |-> (rd_a_data == rd_b_data));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .rd_a_name (rd_a_name),
  .rd_a_data (rd_a_data),
  .rd_b_name (rd_b_name),
  .rd_b_data (rd_b_data),
  .wr_en     (wr_en),
  .wr_name   (wr_name),
  .wr_data   (wr_data)
);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  localparam int DW = 32;
  localparam int NV = 16;
  // {req(4), wen(1), wmode(3), wname(4), wdata(32), rmode(3), rname(4), exp(32)}
  localparam logic [82:0] VEC [NV] = '{
    {4'd1,  1'b1, 3'd0, 4'd3,  32'h11110003, 3'd3, 4'd3,  32'h11110003}, // R1 user->super
    {4'd2,  1'b1, 3'd0, 4'd9,  32'h00000009, 3'd2, 4'd9,  32'h00000009}, // R2 irq sees user R9
    {4'd2,  1'b1, 3'd1, 4'd9,  32'hF0000009, 3'd1, 4'd9,  32'hF0000009}, // R2 fast private
    {4'd6,  1'b0, 3'd0, 4'd9,  32'hDEADBEEF, 3'd0, 4'd9,  32'h00000009}, // R6 disabled, R2 user kept
    {4'd3,  1'b1, 3'd3, 4'd13, 32'h5C000013, 3'd3, 4'd13, 32'h5C000013}, // R3 super SP
    {4'd3,  1'b0, 3'd3, 4'd13, 32'h00000000, 3'd0, 4'd13, 32'h00000000}, // R3 user SP untouched
    {4'd3,  1'b1, 3'd6, 4'd13, 32'h00005013, 3'd0, 4'd13, 32'h00005013}, // R3 system shares user
    {4'd4,  1'b1, 3'd2, 4'd14, 32'h1E000014, 3'd4, 4'd14, 32'h00000000}, // R4 abort LR separate
    {4'd4,  1'b0, 3'd2, 4'd14, 32'h00000000, 3'd2, 4'd14, 32'h1E000014}, // R4 irq LR
    {4'd5,  1'b1, 3'd5, 4'd15, 32'h0F0F0015, 3'd1, 4'd15, 32'h0F0F0015}, // R5 unbanked
    {4'd3,  1'b1, 3'd4, 4'd13, 32'hAB000013, 3'd5, 4'd13, 32'h00000000}, // R3 undef SP separate
    {4'd3,  1'b0, 3'd4, 4'd13, 32'h00000000, 3'd4, 4'd13, 32'hAB000013}, // R3 abort SP
    {4'd2,  1'b1, 3'd1, 4'd12, 32'hF000000C, 3'd3, 4'd12, 32'h00000000}, // R2 fast R12 private
    {4'd1,  1'b1, 3'd1, 4'd0,  32'h00000AA0, 3'd5, 4'd0,  32'h00000AA0}, // R1 fast->undef
    {4'd10, 1'b1, 3'd7, 4'd10, 32'h7000000A, 3'd0, 4'd10, 32'h7000000A}, // R10 reserved=user
    {4'd4,  1'b1, 3'd0, 4'd14, 32'h0000E014, 3'd1, 4'd14, 32'h00000000}  // R4 fast LR private
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    mode;
  logic [3:0]    rd_a_name, rd_b_name, wr_name;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic          wr_en;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done  = 1'b0;

  always #10 clk = ~clk;

  banked_regfile #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .mode(mode),
    .rd_a_name(rd_a_name), .rd_a_data(rd_a_data),
    .rd_b_name(rd_b_name), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_name(wr_name), .wr_data(wr_data)
  );

  task automatic check(input int req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] m, input logic [3:0] n, input logic [DW-1:0] d);
    @(negedge clk);
    mode = m; wr_en = 1'b1; wr_name = n; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    rst = 1'b1; mode = 3'd0; wr_en = 1'b0; wr_name = '0; wr_data = '0;
    rd_a_name = '0; rd_b_name = '0;
    do_reset();
    // R8: reset state
    rd_a_name = 4'd0; rd_b_name = 4'd13; #2;
    check(8, rd_a_data, 32'h0);
    check(8, rd_b_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i][78]; mode = VEC[i][77:75]; wr_name = VEC[i][74:71];
      wr_data = VEC[i][70:39];
      @(negedge clk);
      wr_en = 1'b0; mode = VEC[i][38:36];
      rd_a_name = VEC[i][35:32]; rd_b_name = VEC[i][35:32];
      #2;
      check(int'(VEC[i][82:79]), rd_a_data, VEC[i][31:0]);
      check(int'(VEC[i][82:79]), rd_b_data, VEC[i][31:0]);
    end

    // R9: two ports read different names
    wr(3'd0, 4'd1, 32'h00000111);
    wr(3'd0, 4'd2, 32'h00000222);
    mode = 3'd2; rd_a_name = 4'd1; rd_b_name = 4'd2; #2;
    check(9, rd_a_data, 32'h00000111);
    check(9, rd_b_data, 32'h00000222);

    // R7: read of entry under write returns old value until the edge
    @(negedge clk);
    mode = 3'd1; wr_en = 1'b1; wr_name = 4'd13; wr_data = 32'h12345678;
    rd_a_name = 4'd13; rd_b_name = 4'd13; #2;
    check(7, rd_a_data, 32'h0);
    @(posedge clk); #2;
    check(7, rd_a_data, 32'h12345678);
    @(negedge clk);
    wr_en = 1'b0;

    // R8: reset clears written words
    do_reset();
    mode = 3'd0; rd_a_name = 4'd9; rd_b_name = 4'd15; #2;
    check(8, rd_a_data, 32'h0);
    check(8, rd_b_data, 32'h0);
    mode = 3'd1; rd_a_name = 4'd13; #2;
    check(8, rd_a_data, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule